// File: doc/BRIEF.md
# Embedded Operation Status Generator

This block supplies the status bits a flash-style memory returns on reads while an embedded program or erase algorithm is in progress, suspended, or briefly running against protected sectors. The surrounding control logic reports the kind of operation, whether the algorithm is busy, whether an erase is suspended, whether the internal time limit has been exceeded, and bit 7 of the byte last written. From these inputs the block produces the polling bit (bit 7), the general toggle bit (bit 6), the time-limit bit (bit 5) and the sector toggle bit (bit 2). It also produces a flag that tells the read path to drive status rather than array data.

The two toggle bits count read cycles. A read cycle is the interval in which both active-low chip enable and output enable are asserted. The cycle ends when either strobe is released, so either strobe can clock the reads. A command pulse with a flag meaning that every targeted sector is protected opens a short window, about 2 us long. During the window the toggle bit runs, and then the read path returns to the array. The window length in clock cycles comes from the clock frequency parameter.

Top module: `op_status_gen`

## Requirements
- R1: After reset, status_on, st_q6 and st_q2 are 0.
- R2: For a program (op_erase=0), st_q7 is the inverse of wr_bit7 while the algorithm runs, and equals wr_bit7 once status_on has fallen.
- R3: For an erase (op_erase=1), st_q7 is 0 while the algorithm runs. It is 1 once the erase is over, and 1 while the erase is suspended with no program running.
- R4: While op_busy is 1, st_q6 inverts once for each read cycle. A read cycle ends when ce_n or oe_n rises while the other strobe is low. The change appears after the clock edge at which the end of the read is first seen.
- R5: While op_suspended is 1 and op_busy is 0, st_q6 holds its value. A program run during the suspension (op_busy=1) makes it toggle again.
- R6: An op_start pulse with target_prot=1 holds status_on at 1 and lets st_q6 toggle on reads for PROT_CYCLES clock cycles, counted from the next edge. After that, status_on returns to 0.
- R7: st_q5 equals time_over while status_on is 1, and is 0 otherwise.
- R8: st_q2 inverts at the end of a read cycle only when rd_in_erase_sector is 1 and an erase is running or suspended. Reads outside that sector leave it unchanged.
- R9: With no operation active, read cycles change neither st_q6 nor st_q2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_erase | input | 1 | Operation kind: 1 erase, 0 program |
| op_busy | input | 1 | Embedded algorithm running (includes the erase time-out) |
| op_suspended | input | 1 | Erase is suspended |
| op_start | input | 1 | One-cycle pulse when the final command write completes |
| target_prot | input | 1 | All targeted sectors are protected (sampled with op_start) |
| time_over | input | 1 | Internal time limit exceeded |
| wr_bit7 | input | 1 | Bit 7 of the last written byte |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_in_erase_sector | input | 1 | Read address lies in an erasing or suspended sector |
| status_on | output | 1 | Read path should return status instead of array data |
| st_q7 | output | 1 | Polling bit |
| st_q6 | output | 1 | General toggle bit |
| st_q5 | output | 1 | Time limit exceeded bit |
| st_q2 | output | 1 | Sector toggle bit |

## Verification
Bits 7 and 5 and the status flag follow the operation inputs in the same cycle. The exception is the protected window, which starts one edge after the start pulse and lasts PROT_CYCLES cycles. The toggle bits change one clock edge after a strobe is released. The bench drives inputs a little after each falling clock edge. It updates a behavioural model at each rising edge and compares all five outputs with the model at the next falling edge. Every comparison is therefore made after the edge that could change the result and before any new stimulus arrives.

// File: rtl/op_status_gen.sv
module op_status_gen #(
  parameter int CLK_MHZ = 125,
  parameter int PROT_NS = 2000,
  localparam int PROT_CYCLES = CLK_MHZ * PROT_NS / 1000,
  localparam int CW = $clog2(PROT_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic op_erase,
  input  logic op_busy,
  input  logic op_suspended,
  input  logic op_start,
  input  logic target_prot,
  input  logic time_over,
  input  logic wr_bit7,
  input  logic ce_n,
  input  logic oe_n,
  input  logic rd_in_erase_sector,
  output logic status_on,
  output logic st_q7,
  output logic st_q6,
  output logic st_q5,
  output logic st_q2
);

  logic          rd_act, rd_act_q, rd_end;
  logic          tog6, tog2;
  logic [CW-1:0] prot_cnt;
  logic          prot_on, running;

  assign rd_act  = !ce_n && !oe_n;
  assign rd_end  = rd_act_q && !rd_act;
  assign prot_on = prot_cnt != '0;
  assign running = op_busy || prot_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_act_q <= 1'b0;
      tog6     <= 1'b0;
      tog2     <= 1'b0;
      prot_cnt <= '0;
    end else begin
      rd_act_q <= rd_act;
      if (rd_end && running)
        tog6 <= !tog6;
      if (rd_end && rd_in_erase_sector && ((op_erase && op_busy) || op_suspended))
        tog2 <= !tog2;
      if (op_start && target_prot)
        prot_cnt <= CW'(PROT_CYCLES);
      else if (prot_on)
        prot_cnt <= prot_cnt - 1'b1;
    end
  end

  assign status_on = running || op_suspended;
  assign st_q6 = tog6;
  assign st_q2 = tog2;
  assign st_q5 = status_on && time_over;

  always_comb begin
    if (running)
      st_q7 = op_erase ? 1'b0 : !wr_bit7;
    else if (op_suspended)
      st_q7 = 1'b1;
    else
      st_q7 = op_erase ? 1'b1 : wr_bit7;
  end

  // R4 R9
  q6_only_on_read_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_act_q && (ce_n || oe_n)) |=> $stable(st_q6));

  // R5
  q6_frozen_in_suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_suspended && !op_busy && !prot_on) |=> $stable(st_q6));

  // R6
  prot_window_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && target_prot) |=> status_on);

  // R7
  q5_quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status_on |-> !st_q5);

  // R8
  q2_sector_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_in_erase_sector |=> $stable(st_q2));

  // R3
  erase_poll_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_erase && op_busy) |-> !st_q7);

endmodule

// File: tb/op_status_gen_test.sv
module op_status_gen_test;
  localparam int PROT = 125 * 2000 / 1000;

  logic clk = 0, rst_n = 0;
  logic op_erase = 0, op_busy = 0, op_suspended = 0, op_start = 0;
  logic target_prot = 0, time_over = 0, wr_bit7 = 0;
  logic ce_n = 1, oe_n = 1, rd_in_erase_sector = 0;
  logic status_on, st_q7, st_q6, st_q5, st_q2;

  int checks = 0, fails = 0;
  string cur = "R1";

  op_status_gen uut (.*);

  always #4 clk = !clk;

  int m_cnt = 0;
  bit m_q6 = 0, m_q2 = 0, m_rd = 0;

  always @(posedge clk) begin
    bit rd_now;
    rd_now = !ce_n && !oe_n;
    if (!rst_n) begin
      m_cnt = 0; m_q6 = 0; m_q2 = 0; m_rd = 0;
    end else begin
      if (m_rd && !rd_now) begin
        if (op_busy || m_cnt > 0) m_q6 = !m_q6;
        if (rd_in_erase_sector && (op_suspended || (op_erase && op_busy))) m_q2 = !m_q2;
      end
      if (op_start && target_prot) m_cnt = PROT;
      else if (m_cnt > 0) m_cnt--;
      m_rd = rd_now;
    end
  end

  task automatic chk(string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%b exp=%b t=%0t", cur, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    bit run, on, e7;
    run = op_busy || m_cnt > 0;
    on = run || op_suspended;
    if (run) e7 = op_erase ? 1'b0 : !wr_bit7;
    else if (op_suspended) e7 = 1'b1;
    else e7 = op_erase ? 1'b1 : wr_bit7;
    chk("status_on", status_on, on);
    chk("q7", st_q7, e7);
    chk("q6", st_q6, m_q6);
    chk("q5", st_q5, on && time_over);
    chk("q2", st_q2, m_q2);
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic rd(bit via_oe);
    if (via_oe) begin ce_n = 0; step(); oe_n = 0; end
    else begin oe_n = 0; step(); ce_n = 0; end
    step(2);
    if (via_oe) oe_n = 1; else ce_n = 1;
    step();
    ce_n = 1; oe_n = 1;
    step();
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit prev;
    step(3);
    cur = "R1";
    chk("status_on", status_on, 0);
    chk("q6", st_q6, 0);
    chk("q2", st_q2, 0);
    rst_n = 1; step();

    cur = "R9";
    rd_in_erase_sector = 1;
    for (int i = 0; i < 3; i++) rd(i[0]);
    chk("q6 idle", st_q6, 0);
    chk("q2 idle", st_q2, 0);
    rd_in_erase_sector = 0;

    cur = "R2 R4";
    wr_bit7 = 1; op_start = 1; step(); op_start = 0; op_busy = 1;
    for (int i = 0; i < 5; i++) begin prev = st_q6; rd(i[0]); chk("q6 flip", st_q6, !prev); end
    chk("q7 prog", st_q7, 0);
    op_busy = 0; step();
    chk("q7 done", st_q7, 1);

    cur = "R3 R8";
    op_erase = 1; op_start = 1; step(); op_start = 0; op_busy = 1;
    for (int i = 0; i < 6; i++) begin rd_in_erase_sector = i[1]; rd(i[0]); end
    chk("q7 erase", st_q7, 0);

    cur = "R5";
    op_busy = 0; op_suspended = 1; rd_in_erase_sector = 1;
    prev = st_q6;
    for (int i = 0; i < 3; i++) rd(i[0]);
    chk("q6 held", st_q6, prev);
    chk("q7 susp", st_q7, 1);
    op_erase = 0; op_busy = 1; wr_bit7 = 0;
    for (int i = 0; i < 3; i++) begin rd_in_erase_sector = i[0]; rd(1); end
    op_busy = 0; op_erase = 1; step();
    op_suspended = 0; op_busy = 1;

    cur = "R7";
    rd(0); time_over = 1; step(2);
    chk("q5 set", st_q5, 1);
    op_busy = 0; step(2);
    chk("q5 idle", st_q5, 0);
    chk("q7 erase done", st_q7, 1);
    time_over = 0;

    cur = "R6";
    op_erase = 0; wr_bit7 = 1; target_prot = 1; op_start = 1; step();
    op_start = 0; target_prot = 0;
    for (int i = 0; i < 4; i++) rd(i[0]);
    step(PROT);
    chk("window closed", status_on, 0);
    rd(1);
    op_erase = 1; target_prot = 1; op_start = 1; step();
    op_start = 0; target_prot = 0; time_over = 1;
    rd(0); rd(1);
    step(PROT);
    time_over = 0; step(2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule